// File: doc/BRIEF.md
# Security-Aware Pending Interrupt Priority Resolver

This block looks at a parameterised set of interrupt lines. Each line has a pending flag, an enable flag, an 8-bit programmed priority and a secure/non-secure attribute. From these it picks the one most urgent line that is both pending and enabled. A lower priority value is more urgent. The block registers the winning line index, the winner's effective group priority and a valid flag. Software-visible registers, preemption against a running level and exception entry are handled outside the block.

A 3-bit grouping field splits each priority into two parts. The upper bits form a preempting group level and the lower bits form a subpriority. Only the top `IMPL_BITS` bits of every priority are kept, and the others count as zero. A control input can push every non-secure line behind secure lines. It does this by moving the non-secure group level one place to the right and setting the top bit.

The lines are resolved in fixed sub-trees first. Each sub-tree returns its best secure line and its best non-secure line, compared on raw priority. A merge stage then remaps the non-secure candidates and compares all sub-tree results. The merge key is one bit wider than the implemented priority. Because of this, a shifted-out bit never makes two different non-secure group levels look equal.

Top module: `prio_resolver`

## Requirements
- R1: While `rst` is high at a clock edge, the next outputs are `win_valid_o`=0, `win_idx_o`=0 and `win_grp_o`=0, whatever the inputs are.
- R2: A line can win only if both its `pend_i` and `en_i` bits are 1. When no line qualifies, the next outputs are valid=0, index=0 and group=0.
- R3: Only priority bits [7:8-IMPL_BITS] take part in the selection. With IMPL_BITS=3, the priorities 0x5F and 0x40 are equal, and 0x3F beats 0x40.
- R4: For grouping value g, priority bits [7:g+1] are the group level and bits [g:0] are the subpriority. The lower group level wins. When group levels are equal, the lower subpriority wins. With g=7 the group level is always zero.
- R5: When the group level and the subpriority are both equal, the lower line index wins. This holds inside one sub-tree and across sub-trees.
- R6: `win_grp_o` is IMPL_BITS+1 bits wide. For a secure winner, or when `deprio_ns_i`=0, it equals the implemented group bits with a 0 appended below them. For a non-secure winner with `deprio_ns_i`=1, it equals a 1 followed by the implemented group bits. With IMPL_BITS=3, a non-secure group 0b111 maps to 15 and maps to 14 without deprioritisation.
- R7: When `deprio_ns_i`=1, two non-secure lines with different group levels keep their order, whichever sub-trees they sit in. For example, with IMPL_BITS=3 and g=4, priority 0x00 always beats 0x20.
- R8: When `deprio_ns_i`=1, a secure line with priority 0x40 beats a non-secure line with priority 0x00. When `deprio_ns_i`=0, the non-secure 0x00 line wins.
- R9: When a secure effective group level equals a remapped non-secure one (secure 0x80 against non-secure 0x00 under deprioritisation), the tie goes to subpriority and then to the lower index.
- R10: The outputs change only at a clock edge. They reflect the inputs present at that edge, so new inputs appear one cycle later.
- R11: A non-secure line with a lower raw priority in the same sub-tree never hides a secure line that is more urgent after remapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pend_i | input | NUM_LINES | Pending flag per line |
| en_i | input | NUM_LINES | Enable flag per line |
| secure_i | input | NUM_LINES | 1 = line is secure |
| prio_i | input | NUM_LINES x 8 | Programmed priority per line |
| grp_sel_i | input | 3 | Group/subpriority split point g |
| deprio_ns_i | input | 1 | Deprioritise non-secure lines |
| win_valid_o | output | 1 | A qualifying line exists |
| win_idx_o | output | log2(NUM_LINES) | Index of the winning line |
| win_grp_o | output | IMPL_BITS+1 | Effective group level of the winner |

## Verification
The most likely internal faults are a sub-tree that picks the wrong domain candidate and a merge key that drops the bit shifted out by the remap. Either fault shows up as a wrong `win_idx_o` one clock after a pair of competing lines is applied. Because of this, the stimulus always places rival lines both inside one sub-tree and across sub-tree boundaries. A fault in the key construction also shows up in the same cycle on `win_grp_o`, whose top and bottom bits encode the domain remap.

// File: rtl/prio_pkg.sv
package prio_pkg;

    localparam int PRIO_W    = 8;
    localparam int GSEL_W    = 3;
    localparam int KEY_W     = PRIO_W + 1;
    localparam int IDX_W_MAX = 10;

    typedef logic [IDX_W_MAX-1:0] line_idx_t;

    typedef enum logic {
        DOM_NS = 1'b0,
        DOM_S  = 1'b1
    } domain_e;

    // candidate as seen inside a sub-tree: masked raw priority
    typedef struct packed {
        logic              vld;
        logic [PRIO_W-1:0] pr;
        line_idx_t         idx;
    } raw_cand_t;

    // candidate as seen by the merge stage: widened effective group key
    typedef struct packed {
        logic              vld;
        logic [KEY_W-1:0]  key;
        logic [PRIO_W-1:0] sub;
        line_idx_t         idx;
    } eff_cand_t;

    // ones in the implemented (top) priority bits
    function automatic logic [PRIO_W-1:0] impl_mask(int bits);
        logic [PRIO_W-1:0] m;
        for (int i = 0; i < PRIO_W; i++)
            m[i] = (i >= PRIO_W - bits);
        return m;
    endfunction

    // ones in the group bits for split point g: bits [7:g+1]
    function automatic logic [PRIO_W-1:0] grp_mask(logic [GSEL_W-1:0] g);
        logic [PRIO_W-1:0] m;
        for (int i = 0; i < PRIO_W; i++)
            m[i] = (i > int'(g));
        return m;
    endfunction

    // raw order: priority value, then index
    function automatic logic raw_better(raw_cand_t a, raw_cand_t b);
        return a.vld && (!b.vld || (a.pr < b.pr) ||
                         ((a.pr == b.pr) && (a.idx < b.idx)));
    endfunction

    // effective order: group key, then subpriority, then index
    function automatic logic eff_better(eff_cand_t a, eff_cand_t b);
        logic key_eq;
        logic sub_eq;
        key_eq = (a.key == b.key);
        sub_eq = (a.sub == b.sub);
        return a.vld && (!b.vld || (a.key < b.key) ||
                         (key_eq && (a.sub < b.sub)) ||
                         (key_eq && sub_eq && (a.idx < b.idx)));
    endfunction

    // remap a sub-tree winner into the merge domain
    function automatic eff_cand_t to_eff(raw_cand_t c, domain_e dom,
                                         logic deprio, logic [GSEL_W-1:0] g);
        eff_cand_t         e;
        logic [PRIO_W-1:0] gm;
        logic [PRIO_W-1:0] grp;
        gm    = grp_mask(g);
        grp   = c.pr & gm;
        e.vld = c.vld;
        e.idx = c.idx;
        e.sub = c.pr & ~gm;
        if ((dom == DOM_NS) && deprio)
            e.key = {1'b1, grp};
        else
            e.key = {grp, 1'b0};
        return e;
    endfunction

endpackage

// File: rtl/prio_subtree.sv
module prio_subtree
    import prio_pkg::*;
#(
    parameter int LINES     = 8,
    parameter int BASE      = 0,
    parameter int IMPL_BITS = 3
) (
    input  logic [LINES-1:0]             req_i,
    input  logic [LINES-1:0]             sec_i,
    input  logic [LINES-1:0][PRIO_W-1:0] prio_i,
    output raw_cand_t [1:0]              win_o
);

    localparam logic [PRIO_W-1:0] IMASK = impl_mask(IMPL_BITS);

    raw_cand_t [LINES-1:0] line_c;

    always_comb begin
        for (int i = 0; i < LINES; i++) begin
            line_c[i].vld = req_i[i];
            line_c[i].pr  = prio_i[i] & IMASK;
            line_c[i].idx = line_idx_t'(BASE + i);
        end
    end

    // one winner per security domain, chosen on raw priority
    generate
        for (genvar d = 0; d < 2; d++) begin : g_dom
            always_comb begin
                raw_cand_t c;
                win_o[d] = '0;
                for (int i = 0; i < LINES; i++) begin
                    c     = line_c[i];
                    c.vld = line_c[i].vld && (sec_i[i] == (d == 1));
                    if (raw_better(c, win_o[d]))
                        win_o[d] = c;
                end
            end

            // R11: no same-domain request beats the domain winner
            always_comb begin
                for (int i = 0; i < LINES; i++) begin
                    if (req_i[i] && (sec_i[i] == (d == 1)))
                        a_raw_min_r11: assert (win_o[d].vld &&
                                               !(line_c[i].pr < win_o[d].pr));
                end
            end
        end
    endgenerate

endmodule

// File: rtl/prio_merge.sv
module prio_merge
    import prio_pkg::*;
#(
    parameter int NTREE = 4,
    parameter int IDX_W = 5,
    parameter int KW    = 4
) (
    input  raw_cand_t [NTREE-1:0][1:0] cand_i,
    input  logic                       deprio_i,
    input  logic [GSEL_W-1:0]          gsel_i,
    output logic                       win_vld_o,
    output logic [IDX_W-1:0]           win_idx_o,
    output logic [KW-1:0]              win_grp_o
);

    eff_cand_t [NTREE-1:0][1:0] eff;
    eff_cand_t                  best;

    always_comb begin
        for (int t = 0; t < NTREE; t++) begin
            eff[t][DOM_NS] = to_eff(cand_i[t][DOM_NS], DOM_NS, deprio_i, gsel_i);
            eff[t][DOM_S]  = to_eff(cand_i[t][DOM_S],  DOM_S,  deprio_i, gsel_i);
        end
    end

    always_comb begin
        best = '0;
        for (int t = 0; t < NTREE; t++)
            for (int d = 0; d < 2; d++)
                if (eff_better(eff[t][d], best))
                    best = eff[t][d];
    end

    assign win_vld_o = best.vld;
    assign win_idx_o = best.idx[IDX_W-1:0];
    assign win_grp_o = best.key[KEY_W-1 -: KW];

    // R4: no valid sub-tree candidate carries a smaller group key than the winner
    always_comb begin
        for (int t = 0; t < NTREE; t++)
            for (int d = 0; d < 2; d++)
                if (eff[t][d].vld)
                    a_min_key_r4: assert (best.vld && !(eff[t][d].key < best.key));
    end

endmodule

// File: rtl/prio_resolver.sv
module prio_resolver
    import prio_pkg::*;
#(
    parameter int NUM_LINES  = 32,
    parameter int TREE_LINES = 8,
    parameter int IMPL_BITS  = 3
) (
    input  logic                                    clk,
    input  logic                                    rst,
    input  logic [NUM_LINES-1:0]                    pend_i,
    input  logic [NUM_LINES-1:0]                    en_i,
    input  logic [NUM_LINES-1:0]                    secure_i,
    input  logic [NUM_LINES-1:0][PRIO_W-1:0]        prio_i,
    input  logic [GSEL_W-1:0]                       grp_sel_i,
    input  logic                                    deprio_ns_i,
    output logic                                    win_valid_o,
    output logic [$clog2(NUM_LINES)-1:0]            win_idx_o,
    output logic [IMPL_BITS:0]                      win_grp_o
);

    localparam int NTREE = NUM_LINES / TREE_LINES;
    localparam int IDX_W = $clog2(NUM_LINES);
    localparam int KW    = IMPL_BITS + 1;

    if (IMPL_BITS < 3 || IMPL_BITS > PRIO_W) begin : g_bad_impl
        $error("IMPL_BITS out of range");
    end

    logic [NUM_LINES-1:0]       req;
    raw_cand_t [NTREE-1:0][1:0] tree_win;
    logic                       m_vld;
    logic [IDX_W-1:0]           m_idx;
    logic [KW-1:0]              m_grp;

    assign req = pend_i & en_i;

    generate
        for (genvar t = 0; t < NTREE; t++) begin : g_tree
            prio_subtree #(
                .LINES     (TREE_LINES),
                .BASE      (t * TREE_LINES),
                .IMPL_BITS (IMPL_BITS)
            ) u_tree (
                .req_i  (req[t*TREE_LINES +: TREE_LINES]),
                .sec_i  (secure_i[t*TREE_LINES +: TREE_LINES]),
                .prio_i (prio_i[t*TREE_LINES +: TREE_LINES]),
                .win_o  (tree_win[t])
            );
        end
    endgenerate

    prio_merge #(
        .NTREE (NTREE),
        .IDX_W (IDX_W),
        .KW    (KW)
    ) u_merge (
        .cand_i    (tree_win),
        .deprio_i  (deprio_ns_i),
        .gsel_i    (grp_sel_i),
        .win_vld_o (m_vld),
        .win_idx_o (m_idx),
        .win_grp_o (m_grp)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            win_valid_o <= 1'b0;
            win_idx_o   <= '0;
            win_grp_o   <= '0;
        end else begin
            win_valid_o <= m_vld;
            win_idx_o   <= m_idx;
            win_grp_o   <= m_grp;
        end
    end

    // R2: any qualifying request gives a valid result one cycle later
    p_busy_r2: assert property (@(posedge clk) disable iff (rst)
        (|req) |=> win_valid_o);

    // R2: no qualifying request gives an empty, zeroed result
    p_idle_r2: assert property (@(posedge clk) disable iff (rst)
        !(|req) |=> (!win_valid_o && win_idx_o == '0 && win_grp_o == '0));

    // R6: without deprioritisation the appended low key bit stays zero
    p_lsb_r6: assert property (@(posedge clk) disable iff (rst)
        !deprio_ns_i |=> (win_grp_o[0] == 1'b0));

    // R10: unchanged inputs keep the result unchanged
    p_hold_r10: assert property (@(posedge clk) disable iff (rst)
        ($stable(req) && $stable(prio_i) && $stable(secure_i) &&
         $stable(grp_sel_i) && $stable(deprio_ns_i) && !$past(rst))
        |=> $stable(win_idx_o));

endmodule

// File: tb/prio_resolver_bench.sv
module prio_resolver_bench;

    localparam int N = 32;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [N-1:0]      pend_i = '0;
    logic [N-1:0]      en_i = '0;
    logic [N-1:0]      secure_i = '0;
    logic [N-1:0][7:0] prio_i = '0;
    logic [2:0]        grp_sel_i = '0;
    logic              deprio_ns_i = 1'b0;
    logic              win_valid_o;
    logic [4:0]        win_idx_o;
    logic [3:0]        win_grp_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    prio_resolver u_prio_resolver (
        .clk         (clk),
        .rst         (rst),
        .pend_i      (pend_i),
        .en_i        (en_i),
        .secure_i    (secure_i),
        .prio_i      (prio_i),
        .grp_sel_i   (grp_sel_i),
        .deprio_ns_i (deprio_ns_i),
        .win_valid_o (win_valid_o),
        .win_idx_o   (win_idx_o),
        .win_grp_o   (win_grp_o)
    );

    typedef struct packed {
        logic [4:0] ia; logic [7:0] pa; logic sa;
        logic [4:0] ib; logic [7:0] pb; logic sb;
        logic       dep; logic [2:0] gs;
        logic [4:0] ei; logic [3:0] eg; logic [3:0] rq;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t VECS [NV] = '{
        '{5'd3,  8'h60, 1'b1, 5'd10, 8'h40, 1'b1, 1'b0, 3'd0, 5'd10, 4'd4,  4'd4},  // R4
        '{5'd5,  8'h40, 1'b1, 5'd20, 8'h40, 1'b1, 1'b0, 3'd0, 5'd5,  4'd4,  4'd5},  // R5
        '{5'd7,  8'h40, 1'b1, 5'd2,  8'h40, 1'b1, 1'b0, 3'd0, 5'd2,  4'd4,  4'd5},  // R5
        '{5'd1,  8'h5F, 1'b1, 5'd9,  8'h40, 1'b1, 1'b0, 3'd0, 5'd1,  4'd4,  4'd3},  // R3
        '{5'd12, 8'h3F, 1'b1, 5'd4,  8'h40, 1'b1, 1'b0, 3'd0, 5'd12, 4'd2,  4'd3},  // R3
        '{5'd1,  8'h60, 1'b1, 5'd9,  8'h40, 1'b1, 1'b0, 3'd5, 5'd9,  4'd4,  4'd4},  // R4
        '{5'd1,  8'h20, 1'b1, 5'd9,  8'h40, 1'b1, 1'b0, 3'd5, 5'd1,  4'd0,  4'd4},  // R4
        '{5'd2,  8'hE0, 1'b1, 5'd30, 8'h00, 1'b1, 1'b0, 3'd7, 5'd30, 4'd0,  4'd4},  // R4
        '{5'd2,  8'h60, 1'b1, 5'd30, 8'h20, 1'b1, 1'b0, 3'd6, 5'd30, 4'd0,  4'd4},  // R4
        '{5'd3,  8'h20, 1'b0, 5'd12, 8'h00, 1'b0, 1'b1, 3'd4, 5'd12, 4'd8,  4'd7},  // R7
        '{5'd3,  8'h20, 1'b0, 5'd6,  8'h00, 1'b0, 1'b1, 3'd4, 5'd6,  4'd8,  4'd7},  // R7
        '{5'd14, 8'h00, 1'b0, 5'd3,  8'h20, 1'b0, 1'b1, 3'd0, 5'd14, 4'd8,  4'd7},  // R7
        '{5'd20, 8'h40, 1'b1, 5'd1,  8'h00, 1'b0, 1'b1, 3'd0, 5'd20, 4'd4,  4'd8},  // R8
        '{5'd20, 8'h40, 1'b1, 5'd1,  8'h00, 1'b0, 1'b0, 3'd0, 5'd1,  4'd0,  4'd8},  // R8
        '{5'd9,  8'h80, 1'b1, 5'd2,  8'h00, 1'b0, 1'b1, 3'd0, 5'd2,  4'd8,  4'd9},  // R9
        '{5'd2,  8'h80, 1'b1, 5'd9,  8'h00, 1'b0, 1'b1, 3'd0, 5'd2,  4'd8,  4'd9},  // R9
        '{5'd5,  8'h20, 1'b1, 5'd4,  8'h00, 1'b0, 1'b1, 3'd0, 5'd5,  4'd2,  4'd11}, // R11
        '{5'd0,  8'h60, 1'b0, 5'd8,  8'h40, 1'b0, 1'b1, 3'd5, 5'd8,  4'd10, 4'd6},  // R6
        '{5'd31, 8'hE0, 1'b0, 5'd30, 8'hFF, 1'b0, 1'b1, 3'd0, 5'd30, 4'd15, 4'd6},  // R6
        '{5'd31, 8'hE0, 1'b0, 5'd30, 8'hFF, 1'b0, 1'b0, 3'd0, 5'd30, 4'd14, 4'd6}   // R6
    };

    task automatic check(input string tag, input logic ev, input logic [4:0] ei,
                         input logic [3:0] eg);
        checks++;
        if (win_valid_o !== ev || win_idx_o !== ei || win_grp_o !== eg) begin
            errors++;
            $display("FAIL %s: got valid=%0d idx=%0d grp=%0d expected valid=%0d idx=%0d grp=%0d",
                     tag, win_valid_o, win_idx_o, win_grp_o, ev, ei, eg);
        end
    endtask

    task automatic clear_lines();
        pend_i      = '0;
        en_i        = '0;
        secure_i    = '0;
        prio_i      = '0;
        grp_sel_i   = '0;
        deprio_ns_i = 1'b0;
    endtask

    task automatic apply(input vec_t v);
        clear_lines();
        pend_i[v.ia] = 1'b1; en_i[v.ia] = 1'b1; secure_i[v.ia] = v.sa; prio_i[v.ia] = v.pa;
        pend_i[v.ib] = 1'b1; en_i[v.ib] = 1'b1; secure_i[v.ib] = v.sb; prio_i[v.ib] = v.pb;
        grp_sel_i   = v.gs;
        deprio_ns_i = v.dep;
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 reset idle", 1'b0, 5'd0, 4'd0);
        rst = 1'b0;
        step();

        // table walk
        for (int k = 0; k < NV; k++) begin
            apply(VECS[k]);
            step();
            check($sformatf("R%0d vector %0d", VECS[k].rq, k), 1'b1, VECS[k].ei, VECS[k].eg);
        end

        // R2: disabled or non-pending lines never win
        clear_lines();
        pend_i[3] = 1'b1; prio_i[3] = 8'h00;
        en_i[5] = 1'b1; prio_i[5] = 8'h00;
        pend_i[20] = 1'b1; en_i[20] = 1'b1; secure_i[20] = 1'b1; prio_i[20] = 8'hE0;
        step();
        check("R2 gated lines", 1'b1, 5'd20, 4'd14);

        // R2: nothing qualifies
        clear_lines();
        pend_i[7] = 1'b1;
        step();
        check("R2 empty", 1'b0, 5'd0, 4'd0);

        // R10: one-cycle latency
        apply(VECS[0]);
        #1;
        check("R10 before edge", 1'b0, 5'd0, 4'd0);
        step();
        check("R10 after edge", 1'b1, 5'd10, 4'd4);

        // R1: reset dominates pending inputs
        rst = 1'b1;
        step();
        check("R1 reset with requests", 1'b0, 5'd0, 4'd0);
        rst = 1'b0;
        step();
        check("R1 release", 1'b1, 5'd10, 4'd4);

        finish_run();
    end

    initial begin
        #(20 * 20000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            finish_run();
        end
    end

endmodule